// File: doc/BRIEF.md
# Multiplexed LCD Waveform Generator

This block produces the drive-level codes for every segment and common terminal of a three-common, 1/3-bias multiplexed LCD. Each terminal carries a 2-bit code that an external analog stage turns into one of four voltages: GND, one third, two thirds or the full panel supply. The image comes from a small on-block memory that holds one row of segment bits per common line. A tap on a free-running binary counter, followed by a 3-bit divider, sets how long each drive phase lasts.

Each common slot takes two phases. Three slots make one frame of six phases. In standard mode the two phases of a slot have opposite polarity, so the waveform repeats every frame. In low-power mode both phases of a slot share one polarity, and a frame-parity flop inverts the whole frame on every other frame. The terminals then toggle less often, and the waveform period doubles to two frames. In both modes every pixel sees zero net DC over a period.

The sequencer has three states. `ST_IDLE` parks all outputs at ground. `ST_PH_A` is the first phase of a slot and `ST_PH_B` is the second. The transitions are as follows:
- `ST_IDLE`→`ST_PH_A` when enable is seen. This starts COM0 of frame 0 and clears the parity.
- `ST_PH_A`→`ST_PH_B` on a phase step.
- `ST_PH_B`→`ST_PH_A` on a phase step. This advances the common, and on a wrap from COM2 it toggles the parity and pulses frame start.
- Any state→`ST_IDLE` when enable is low.

Top module: `lcd_wavegen`

## Requirements
- R1: While `enable` is low, every `seg_lvl` and `com_lvl` field is code 0 (GND) in that same cycle, and `frame_start` is 0. After reset, all outputs are 0.
- R2: Dropping and raising `enable` leaves the display memory unchanged. The next enabled run shows the rows that were written before.
- R3: Mode bit value 0 selects low-power mode and value 1 selects standard mode. The mode resets to 1 (standard).
- R4: A mode write (`mode_wr` high) made while `enable` is high is ignored. A write made while `enable` is low takes effect.
- R5: Every phase lasts T×(D+1) clock cycles, where T = 8 when `presc_sel`=0, T = 16 when `presc_sel`=1, and D is `clkdiv`. The first phase starts on the first clock edge that sees `enable` high.
- R6: Commons are scanned in the order 0, 1, 2, with two phases per common. `com_idx` gives the common being driven. `frame_start` is high for exactly the first cycle of each frame, which is the first cycle of COM0.
- R7: Level codes are 0=GND, 1=1/3, 2=2/3, 3=full. With positive polarity, the selected common is at 3 and the other commons are at 1; an on segment is at 0 and an off segment is at 2. Negative polarity swaps 3↔0 and 1↔2. In standard mode the first phase of each slot is positive and the second is negative.
- R8: In low-power mode both phases of a slot have the same polarity. All of frame 0 after enable is positive, frame 1 is negative, and the pattern alternates from there.
- R9: The waveform period is 6 phases in standard mode and 12 phases in low-power mode. Over each period, the sum of (segment code − common code) is zero for every segment/common pair.
- R10: `mem_we` with `mem_row` 0..2 writes `mem_wdata` to that row. Bit s of row c is the pixel at segment s and common c, and 1 means on. A write to `mem_row`=3 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | LCD clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Controller enable |
| mode_wr | input | 1 | Mode bit write strobe |
| mode_wdata | input | 1 | Mode value (0 low-power, 1 standard) |
| presc_sel | input | 1 | Counter tap select (0: /8, 1: /16) |
| clkdiv | input | 3 | Extra divide, factor = value + 1 |
| mem_we | input | 1 | Display memory write strobe |
| mem_row | input | 2 | Row (common) to write |
| mem_wdata | input | N_SEG | Segment bits for the row |
| seg_lvl | output | 2*N_SEG | Level code per segment, segment s at bits [2s+1:2s] |
| com_lvl | output | 6 | Level code per common, common c at bits [2c+1:2c] |
| frame_start | output | 1 | One-cycle pulse at the start of each frame |
| com_idx | output | 2 | Common currently being driven |

## Verification
The image is tried with directed rows (all on, all off, a checkerboard) and with random rows. Every terminal code is compared in the first and last cycle of every phase, so a wrong level, a wrong polarity or a wrong phase length each shows up separately. Both modes run over several tap and divider settings, and per-pixel DC sums show whether the inversion schedule balances over 6 or over 12 phases. A mode write made during a run, a write to row 3, and a disable/re-enable cycle tell a locked mode and a retained memory apart from ones that get disturbed.

// File: rtl/lcd_pkg.sv
package lcd_pkg;

    localparam int NUM_COM = 3;
    localparam int LVL_W   = 2;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PH_A = 2'd1,
        ST_PH_B = 2'd2
    } seq_state_e;

    localparam logic [LVL_W-1:0] LV_GND  = 2'd0;
    localparam logic [LVL_W-1:0] LV_LOW  = 2'd1;
    localparam logic [LVL_W-1:0] LV_HIGH = 2'd2;
    localparam logic [LVL_W-1:0] LV_FULL = 2'd3;

    function automatic logic [LVL_W-1:0] com_code(input logic sel, input logic pos);
        if (sel) return pos ? LV_FULL : LV_GND;
        return pos ? LV_LOW : LV_HIGH;
    endfunction

    function automatic logic [LVL_W-1:0] seg_code(input logic on, input logic pos);
        if (on) return pos ? LV_GND : LV_FULL;
        return pos ? LV_HIGH : LV_LOW;
    endfunction

endpackage

// File: rtl/lcd_timebase.sv
module lcd_timebase #(
    parameter int RIP_W = 4,
    parameter int DIV_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             presc_sel,
    input  logic [DIV_W-1:0] clkdiv,
    output logic             step
);
    logic [RIP_W-1:0] rip_q;
    logic [DIV_W-1:0] div_q;
    logic             tap_hit;

    assign tap_hit = presc_sel ? (&rip_q) : (&rip_q[RIP_W-2:0]);
    assign step    = run && tap_hit && (div_q == clkdiv);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rip_q <= '0;
            div_q <= '0;
        end else if (!run) begin
            rip_q <= '0;
            div_q <= '0;
        end else begin
            rip_q <= rip_q + 1'b1;
            if (tap_hit) div_q <= (div_q == clkdiv) ? '0 : div_q + 1'b1;
        end
    end

    AST_STEP_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> !step); // R5

endmodule

// File: rtl/lcd_seq.sv
module lcd_seq
    import lcd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       enable,
    input  logic       step,
    input  logic       lp_mode,
    output logic       active,
    output logic       pos,
    output logic [1:0] com_idx,
    output logic       frame_start
);
    seq_state_e state_q, state_d;
    logic [1:0] com_q, com_d;
    logic       par_q, par_d;
    logic       fs_q, fs_d;

    always_comb begin
        state_d = state_q;
        com_d   = com_q;
        par_d   = par_q;
        fs_d    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (enable) begin
                    state_d = ST_PH_A;
                    com_d   = 2'd0;
                    par_d   = 1'b0;
                    fs_d    = 1'b1;
                end
            end
            ST_PH_A: begin
                if (!enable)   state_d = ST_IDLE;
                else if (step) state_d = ST_PH_B;
            end
            ST_PH_B: begin
                if (!enable) state_d = ST_IDLE;
                else if (step) begin
                    state_d = ST_PH_A;
                    if (com_q == 2'd2) begin
                        com_d = 2'd0;
                        par_d = ~par_q;
                        fs_d  = 1'b1;
                    end else begin
                        com_d = com_q + 2'd1;
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            com_q   <= 2'd0;
            par_q   <= 1'b0;
            fs_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            com_q   <= com_d;
            par_q   <= par_d;
            fs_q    <= fs_d;
        end
    end

    always_comb begin
        active      = (state_q != ST_IDLE);
        pos         = lp_mode ? ~par_q : (state_q == ST_PH_A);
        com_idx     = com_q;
        frame_start = fs_q && enable;
    end

    AST_DISABLE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> state_q == ST_IDLE); // R1
    AST_COM_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PH_B && step && enable) |=>
            com_q == (($past(com_q) == 2'd2) ? 2'd0 : $past(com_q) + 2'd1)); // R6
    AST_FRAME_AT_COM0: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |-> com_q == 2'd0); // R6
    AST_LP_SLOT_POL: assert property (@(posedge clk) disable iff (!rst_n)
        (lp_mode && state_q == ST_PH_A && step && enable) |=> $stable(pos)); // R8

endmodule

// File: rtl/lcd_segmem.sv
module lcd_segmem #(
    parameter int N_SEG = 8,
    parameter int ROWS  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [1:0]       wrow,
    input  logic [N_SEG-1:0] wdata,
    input  logic [1:0]       rrow,
    output logic [N_SEG-1:0] rdata
);
    logic [N_SEG-1:0] rows_q [ROWS];

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                          rows_q[r] <= '0;
            else if (we && wrow == 2'(r))        rows_q[r] <= wdata;
        end
    end

    assign rdata = (rrow < 2'(ROWS)) ? rows_q[rrow] : '0;

endmodule

// File: rtl/lcd_drive.sv
module lcd_drive
    import lcd_pkg::*;
#(
    parameter int N_SEG = 8
) (
    input  logic                   on,
    input  logic                   pos,
    input  logic [1:0]             com_idx,
    input  logic [N_SEG-1:0]       row_bits,
    output logic [LVL_W*N_SEG-1:0] seg_lvl,
    output logic [LVL_W*NUM_COM-1:0] com_lvl
);
    for (genvar s = 0; s < N_SEG; s++) begin : g_seg
        assign seg_lvl[LVL_W*s +: LVL_W] = on ? seg_code(row_bits[s], pos) : LV_GND;
    end

    for (genvar c = 0; c < NUM_COM; c++) begin : g_com
        assign com_lvl[LVL_W*c +: LVL_W] = on ? com_code(com_idx == 2'(c), pos) : LV_GND;
    end

endmodule

// File: rtl/lcd_wavegen.sv
module lcd_wavegen
    import lcd_pkg::*;
#(
    parameter int N_SEG = 8,
    parameter int DIV_W = 3,
    parameter int RIP_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               enable,
    input  logic               mode_wr,
    input  logic               mode_wdata,
    input  logic               presc_sel,
    input  logic [DIV_W-1:0]   clkdiv,
    input  logic               mem_we,
    input  logic [1:0]         mem_row,
    input  logic [N_SEG-1:0]   mem_wdata,
    output logic [2*N_SEG-1:0] seg_lvl,
    output logic [5:0]         com_lvl,
    output logic               frame_start,
    output logic [1:0]         com_idx
);
    logic             mode_q;
    logic             active, pos, step;
    logic [N_SEG-1:0] row_bits;
    logic [NUM_COM-1:0] com_extreme;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                   mode_q <= 1'b1;
        else if (mode_wr && !enable)  mode_q <= mode_wdata;
    end

    lcd_timebase #(.RIP_W(RIP_W), .DIV_W(DIV_W)) u_tb (
        .clk(clk), .rst_n(rst_n), .run(active && enable),
        .presc_sel(presc_sel), .clkdiv(clkdiv), .step(step)
    );

    lcd_seq u_seq (
        .clk(clk), .rst_n(rst_n), .enable(enable), .step(step),
        .lp_mode(~mode_q), .active(active), .pos(pos),
        .com_idx(com_idx), .frame_start(frame_start)
    );

    lcd_segmem #(.N_SEG(N_SEG), .ROWS(NUM_COM)) u_mem (
        .clk(clk), .rst_n(rst_n), .we(mem_we), .wrow(mem_row),
        .wdata(mem_wdata), .rrow(com_idx), .rdata(row_bits)
    );

    lcd_drive #(.N_SEG(N_SEG)) u_drv (
        .on(active && enable), .pos(pos), .com_idx(com_idx),
        .row_bits(row_bits), .seg_lvl(seg_lvl), .com_lvl(com_lvl)
    );

    for (genvar c = 0; c < NUM_COM; c++) begin : g_ext
        assign com_extreme[c] = (com_lvl[2*c +: 2] == LV_FULL) || (com_lvl[2*c +: 2] == LV_GND);
    end

    AST_MODE_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        enable |=> $stable(mode_q)); // R4
    AST_GROUND_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |-> (seg_lvl == '0 && com_lvl == '0 && !frame_start)); // R1
    AST_ONE_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && active) |-> $countones(com_extreme) == 1); // R6

endmodule

// File: tb/tb_lcd_wavegen.sv
module tb_lcd_wavegen;
    localparam int NS = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          enable = 1'b0;
    logic          mode_wr = 1'b0;
    logic          mode_wdata = 1'b0;
    logic          presc_sel = 1'b0;
    logic [2:0]    clkdiv = 3'd0;
    logic          mem_we = 1'b0;
    logic [1:0]    mem_row = 2'd0;
    logic [NS-1:0] mem_wdata = '0;
    logic [2*NS-1:0] seg_lvl;
    logic [5:0]    com_lvl;
    logic          frame_start;
    logic [1:0]    com_idx;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic [NS-1:0] exp_row [3];
    int dc [NS][3];

    always #2 clk = ~clk;

    lcd_wavegen #(.N_SEG(NS)) dut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .mode_wr(mode_wr),
        .mode_wdata(mode_wdata), .presc_sel(presc_sel), .clkdiv(clkdiv),
        .mem_we(mem_we), .mem_row(mem_row), .mem_wdata(mem_wdata),
        .seg_lvl(seg_lvl), .com_lvl(com_lvl), .frame_start(frame_start),
        .com_idx(com_idx)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic bit pol_of(int k, bit lp);
        if (lp) return ((k / 6) % 2) == 0;
        return (k % 2) == 0;
    endfunction

    function automatic logic [5:0] e_com(int k, bit lp);
        logic [5:0] v;
        bit p = pol_of(k, lp);
        int slot = (k % 6) / 2;
        for (int c = 0; c < 3; c++)
            v[2*c +: 2] = (c == slot) ? (p ? 2'd3 : 2'd0) : (p ? 2'd1 : 2'd2);
        return v;
    endfunction

    function automatic logic [2*NS-1:0] e_seg(int k, bit lp);
        logic [2*NS-1:0] v;
        bit p = pol_of(k, lp);
        int slot = (k % 6) / 2;
        for (int s = 0; s < NS; s++)
            v[2*s +: 2] = exp_row[slot][s] ? (p ? 2'd0 : 2'd3) : (p ? 2'd2 : 2'd1);
        return v;
    endfunction

    task automatic wr_row(input logic [1:0] r, input logic [NS-1:0] d);
        @(negedge clk);
        mem_we = 1'b1; mem_row = r; mem_wdata = d;
        @(negedge clk);
        mem_we = 1'b0;
        if (r != 2'd3) exp_row[r] = d;
    endtask

    task automatic wr_mode(input logic m);
        @(negedge clk);
        mode_wr = 1'b1; mode_wdata = m;
        @(negedge clk);
        mode_wr = 1'b0;
    endtask

    // Checks phases k0..k0+n-1; call with enable already high since the phase-0 edge.
    task automatic run_phases(input int k0, input int n, input int plen, input bit lp);
        int per = lp ? 12 : 6;
        for (int k = k0; k < k0 + n; k++) begin
            @(negedge clk);
            if (k % per == 0)
                for (int s = 0; s < NS; s++) for (int c = 0; c < 3; c++) dc[s][c] = 0;
            chk(com_lvl == e_com(k, lp), lp ? "R8 com level" : "R7 com level", com_lvl, e_com(k, lp));
            chk(seg_lvl == e_seg(k, lp), lp ? "R8 seg level" : "R7 seg level", seg_lvl, e_seg(k, lp));
            chk(com_idx == 2'((k % 6) / 2), "R6 com_idx", com_idx, (k % 6) / 2);
            chk(frame_start == (k % 6 == 0), "R6 frame_start first cycle", frame_start, k % 6 == 0);
            for (int s = 0; s < NS; s++)
                for (int c = 0; c < 3; c++)
                    dc[s][c] += int'(seg_lvl[2*s +: 2]) - int'(com_lvl[2*c +: 2]);
            repeat (plen - 1) @(negedge clk);
            chk(com_lvl == e_com(k, lp) && seg_lvl == e_seg(k, lp), "R5 phase length",
                {seg_lvl, com_lvl}, {e_seg(k, lp), e_com(k, lp)});
            if (plen > 1) chk(frame_start == 1'b0, "R6 frame_start width", frame_start, 0);
            if (k % per == per - 1) begin
                bit zero = 1;
                for (int s = 0; s < NS; s++) for (int c = 0; c < 3; c++) if (dc[s][c] != 0) zero = 0;
                chk(zero, "R9 net DC per period", !zero, 0);
            end
        end
    endtask

    task automatic start_run(input bit ps, input logic [2:0] dv);
        @(negedge clk);
        presc_sel = ps; clkdiv = dv; enable = 1'b1;
    endtask

    task automatic stop_run();
        @(negedge clk);
        enable = 1'b0;
        #1;
        chk(seg_lvl == '0 && com_lvl == '0 && frame_start == 1'b0, "R1 ground on disable",
            {seg_lvl, com_lvl}, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    initial begin
        int plen;
        void'($urandom(32'd2024));
        for (int r = 0; r < 3; r++) exp_row[r] = '0;
        repeat (3) @(negedge clk);
        chk(seg_lvl == '0 && com_lvl == '0 && frame_start == 1'b0, "R1 reset state", {seg_lvl, com_lvl}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R10: rows 0..2 written, row 3 write ignored
        wr_row(2'd0, 8'hFF);
        wr_row(2'd1, 8'h00);
        wr_row(2'd2, 8'hA5);
        wr_row(2'd3, 8'h3C);

        // R3: reset mode is standard; R5 with /8 tap, no extra divide
        start_run(1'b0, 3'd0);
        run_phases(0, 12, 8, 1'b0);
        // R4: mode write during run ignored, waveform stays standard
        fork
            run_phases(12, 6, 8, 1'b0);
            wr_mode(1'b0);
        join
        stop_run();
        repeat (3) @(negedge clk);
        chk(seg_lvl == '0 && com_lvl == '0, "R1 stays ground while disabled", {seg_lvl, com_lvl}, 0);

        // R3/R4: write while disabled selects low-power; R2 image retained
        wr_mode(1'b0);
        start_run(1'b1, 3'd2);
        run_phases(0, 24, 48, 1'b1);
        stop_run();

        // Back to standard with /16 tap
        wr_mode(1'b1);
        start_run(1'b1, 3'd0);
        run_phases(0, 6, 16, 1'b0);
        stop_run();

        // Random rows, modes, taps and divides
        for (int it = 0; it < 8; it++) begin
            bit lp = 1'($urandom % 2);
            bit ps = 1'($urandom % 2);
            logic [2:0] dv = 3'($urandom % 4);
            for (int r = 0; r < 3; r++) wr_row(2'(r), NS'($urandom));
            wr_mode(~lp);
            plen = (ps ? 16 : 8) * (int'(dv) + 1);
            start_run(ps, dv);
            run_phases(0, 12, plen, lp);
            stop_run();
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule